// File: doc/BRIEF.md
# DMA Source-Chain Tag Walker

This block is one DMA channel that walks a linked list of 64-bit tags held in memory. A tag is fetched from the tag-address register. Its 3-bit ID picks the rule for two things: where the payload is read from, and where the next tag sits. The payload quadwords are then streamed out in order, and the walker moves on to the next tag or stops. Call and return tags let a list jump into a shared sub-list and come back through a two-entry address stack.

Software loads the address registers through a small register port. It then writes the control register with the start bit set. The start bit reads back as busy until the walk ends. All addresses count 128-bit quadwords. A memory port issues one read at a time and waits for the returned quadword. Each payload quadword, and each tag when tag emission is enabled, leaves on a valid-qualified output stream.

Top module: `chain_walker`

## Requirements
- R1: After reset every register reads zero, and `mem_req_o`, `out_valid_o` and `irq_o` are low.
- R2: The register select codes are: 0 control, 1 memory address, 2 quadword count, 3 tag address, 4 stack entry 0, 5 stack entry 1. Writes take effect only while the channel is idle (control bit 8 reads 0). A write while busy is ignored.
- R3: Tag layout is: count in bits 15:0, priority control in 27:26, ID in 30:28, interrupt flag in bit 31, address in 62:32, memory select in bit 63. Control bits 31:16 capture tag bits 31:16 of every fetched tag. The other control fields are: direction bit 0, mode 3:2, stack pointer 5:4, tag emission 6, interrupt enable 7, start/busy 8.
- R4: ID 1 reads the payload from the quadword after the tag. The next tag is the quadword after the payload.
- R5: ID 2 reads the payload after the tag and takes the next tag from the address field. ID 7 does the same but ends the walk after its payload, leaving the address field in the tag-address register.
- R6: ID 3 reads the payload at the address field and takes the next tag from the quadword after the tag. ID 0 does the same but ends the walk after its payload.
- R7: ID 4 behaves as ID 3, except that no payload read is issued while `stall_i` is high.
- R8: ID 5 reads the payload after the tag and pushes the address after the payload onto the stack, incrementing the stack pointer. The next tag comes from the address field. If the stack pointer already equals 2, the walk stops at once with no payload and the stack is unchanged.
- R9: ID 6 reads the payload after the tag. With a nonzero stack pointer it pops the top entry as the next tag address. With an empty stack it ends after the payload, leaving the address after the payload in the tag-address register.
- R10: A tag count of zero streams no payload but still applies the ID's next-tag and stack rule.
- R11: When a tag's interrupt flag is set and interrupt enable is on, the walk stops after that tag's payload and the start bit clears. `irq_o` then pulses high for exactly one cycle.
- R12: With tag emission on, each fetched tag quadword is also sent on the output stream ahead of its payload.
- R13: With mode 0 the channel skips tags and streams the count register's quadwords from the memory address register, then stops. Each streamed quadword advances the address and lowers the count by one.
- R14: `mem_req_o` stays high with a constant `mem_addr_o` until `mem_valid_i` returns the quadword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Quadword address of the request |
| mem_valid_i | input | 1 | Read data valid, completes the request |
| mem_data_i | input | 128 | Returned quadword |
| stall_i | input | 1 | Holds stall-controlled payload reads |
| out_valid_o | output | 1 | Output quadword valid |
| out_data_o | output | 128 | Output quadword |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench walks lists that mix every ID. The checks target the call/return path: a nested call that fills the stack, zero-count tags that only move the stack, and a return on an empty stack. A design with a wrong stack index or pop order would resume at the wrong tag, and both the output signature and the final tag address would change. Other cases are a call with a full stack, which must emit nothing, and an interrupt-flagged tag with enable on and off. The last case is a stall-controlled tag held for a long time while the bench writes the registers. A design that let those writes through would jump to a stray tag and finish at the wrong address.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int QW_W      = 128;
  localparam int QCNT_W    = 16;
  localparam int TAG_ID_LSB = 28;
  localparam int TAG_IRQ_BIT = 31;
  localparam int TAG_ADR_LSB = 32;
  localparam int TAG_ADR_W   = 31;

  typedef enum logic [2:0] {
    ID_REFE = 3'd0, ID_CNT = 3'd1, ID_NEXT = 3'd2, ID_REF = 3'd3,
    ID_REFS = 3'd4, ID_CALL = 3'd5, ID_RET = 3'd6, ID_END = 3'd7
  } tag_id_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TAG, ST_STALL, ST_DATA, ST_FIN
  } walk_state_e;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_MADR  = 3'd1;
  localparam logic [2:0] SEL_QCNT  = 3'd2;
  localparam logic [2:0] SEL_TADR  = 3'd3;
  localparam logic [2:0] SEL_STK0  = 3'd4;
endpackage

// File: rtl/cw_tag_decode.sv
module cw_tag_decode
  import cw_pkg::*;
#(
  parameter int ADDR_W = 31
) (
  input  logic [2:0]        id_i,
  input  logic [QCNT_W-1:0] qwc_i,
  input  logic [ADDR_W-1:0] tag_addr_i,
  input  logic [ADDR_W-1:0] taddr_i,
  input  logic              stack_empty_i,
  input  logic              stack_full_i,
  input  logic [ADDR_W-1:0] pop_addr_i,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic [ADDR_W-1:0] next_taddr_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic              push_o,
  output logic              pop_o,
  output logic              last_o,
  output logic              stall_ctl_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] after_tag, after_data;

  assign after_tag   = taddr_i + ADDR_W'(1);
  assign after_data  = after_tag + ADDR_W'(qwc_i);
  assign push_addr_o = after_data;

  always_comb begin
    data_addr_o  = after_tag;
    next_taddr_o = after_tag;
    push_o       = 1'b0;
    pop_o        = 1'b0;
    last_o       = 1'b0;
    stall_ctl_o  = 1'b0;
    err_o        = 1'b0;
    unique case (tag_id_e'(id_i))
      ID_REFE: begin data_addr_o = tag_addr_i; last_o = 1'b1; end
      ID_CNT:  next_taddr_o = after_data;
      ID_NEXT: next_taddr_o = tag_addr_i;
      ID_REF:  data_addr_o = tag_addr_i;
      ID_REFS: begin data_addr_o = tag_addr_i; stall_ctl_o = 1'b1; end
      ID_CALL: begin
        next_taddr_o = tag_addr_i;
        err_o        = stack_full_i;
        push_o       = !stack_full_i;
      end
      ID_RET: begin
        if (stack_empty_i) begin
          next_taddr_o = after_data;
          last_o       = 1'b1;
        end else begin
          next_taddr_o = pop_addr_i;
          pop_o        = 1'b1;
        end
      end
      ID_END:  begin next_taddr_o = tag_addr_i; last_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/cw_addr_stack.sv
module cw_addr_stack #(
  parameter int ADDR_W = 31,
  parameter int DEPTH  = 2,
  parameter int SP_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DEPTH-1:0]  wr_en_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              sp_we_i,
  input  logic [SP_W-1:0]   sp_wdata_i,
  output logic [SP_W-1:0]   sp_o,
  output logic              full_o,
  output logic [ADDR_W-1:0] top_o,
  output logic [ADDR_W-1:0] entry_o [DEPTH]
);
  logic [SP_W-1:0] sp_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                entry_o[g] <= '0;
      else if (wr_en_i[g])                        entry_o[g] <= wr_data_i;
      else if (push_i && sp_q == SP_W'(g))        entry_o[g] <= push_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= '0;
    else if (sp_we_i) sp_q <= (sp_wdata_i > SP_W'(DEPTH)) ? SP_W'(DEPTH) : sp_wdata_i;
    else if (push_i)  sp_q <= sp_q + SP_W'(1);
    else if (pop_i)   sp_q <= sp_q - SP_W'(1);
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top_o = entry_o[i];
  end

  assign sp_o   = sp_q;
  assign full_o = sp_q >= SP_W'(DEPTH);

  a_r8_sp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SP_W'(DEPTH));
  a_r8_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> sp_q < SP_W'(DEPTH));
  a_r9_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> sp_q == $past(sp_q) - SP_W'(1));
endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import cw_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [QW_W-1:0]   mem_data_i,
  input  logic              stall_i,
  output logic              out_valid_o,
  output logic [QW_W-1:0]   out_data_o,
  output logic              irq_o
);
  localparam int SP_W = $clog2(DEPTH + 1);

  walk_state_e       state_q;
  logic              dir_q, tte_q, tie_q, last_q, irq_stop_q;
  logic [1:0]        mode_q;
  logic [15:0]       tag_hi_q;
  logic [ADDR_W-1:0] madr_q, tadr_q;
  logic [QCNT_W-1:0] qcnt_q;

  logic busy, take, idle_wr, ctrl_wr;
  logic [QCNT_W-1:0] t_qwc;
  logic [2:0]        t_id;
  logic [ADDR_W-1:0] t_addr;
  logic [ADDR_W-1:0] d_data, d_next, d_push_addr, stk_top;
  logic d_push, d_pop, d_last, d_stall, d_err, in_tag;
  logic [SP_W-1:0]   sp;
  logic              stk_full;
  logic [DEPTH-1:0]  stk_we;
  logic [ADDR_W-1:0] stk_ent [DEPTH];

  assign busy    = state_q != ST_IDLE;
  assign take    = mem_req_o && mem_valid_i;
  assign in_tag  = state_q == ST_TAG && take;
  assign idle_wr = reg_we_i && !busy;
  assign ctrl_wr = idle_wr && reg_sel_i == SEL_CTRL;

  assign t_qwc  = mem_data_i[QCNT_W-1:0];
  assign t_id   = mem_data_i[TAG_ID_LSB +: 3];
  assign t_addr = ADDR_W'(mem_data_i[TAG_ADR_LSB +: TAG_ADR_W]);

  for (genvar g = 0; g < DEPTH; g++) begin : g_stk_we
    assign stk_we[g] = idle_wr && reg_sel_i == 3'(SEL_STK0 + g);
  end

  cw_tag_decode #(.ADDR_W(ADDR_W)) u_dec (
    .id_i(t_id), .qwc_i(t_qwc), .tag_addr_i(t_addr), .taddr_i(tadr_q),
    .stack_empty_i(sp == '0), .stack_full_i(stk_full), .pop_addr_i(stk_top),
    .data_addr_o(d_data), .next_taddr_o(d_next), .push_addr_o(d_push_addr),
    .push_o(d_push), .pop_o(d_pop), .last_o(d_last), .stall_ctl_o(d_stall),
    .err_o(d_err)
  );

  cw_addr_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_stk (
    .clk_i, .rst_ni,
    .push_i(in_tag && d_push), .pop_i(in_tag && d_pop), .push_addr_i(d_push_addr),
    .wr_en_i(stk_we), .wr_data_i(reg_wdata_i[ADDR_W-1:0]),
    .sp_we_i(ctrl_wr), .sp_wdata_i(SP_W'(reg_wdata_i[5:4])),
    .sp_o(sp), .full_o(stk_full), .top_o(stk_top), .entry_o(stk_ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      {dir_q, tte_q, tie_q, last_q, irq_stop_q, irq_o} <= '0;
      mode_q <= '0; tag_hi_q <= '0;
      madr_q <= '0; tadr_q <= '0; qcnt_q <= '0;
    end else begin
      irq_o <= 1'b0;
      if (idle_wr) begin
        unique case (reg_sel_i)
          SEL_CTRL: begin
            dir_q  <= reg_wdata_i[0];
            mode_q <= reg_wdata_i[3:2];
            tte_q  <= reg_wdata_i[6];
            tie_q  <= reg_wdata_i[7];
            if (reg_wdata_i[8]) begin
              irq_stop_q <= 1'b0;
              last_q     <= 1'b1;
              if (reg_wdata_i[3:2] != 2'd0) state_q <= ST_TAG;
              else state_q <= (qcnt_q != '0) ? ST_DATA : ST_FIN;
            end
          end
          SEL_MADR: madr_q <= reg_wdata_i[ADDR_W-1:0];
          SEL_QCNT: qcnt_q <= reg_wdata_i[QCNT_W-1:0];
          SEL_TADR: tadr_q <= reg_wdata_i[ADDR_W-1:0];
          default: ;
        endcase
      end
      unique case (state_q)
        ST_TAG: if (take) begin
          tag_hi_q <= mem_data_i[31:16];
          if (d_err) state_q <= ST_IDLE;
          else begin
            qcnt_q     <= t_qwc;
            madr_q     <= d_data;
            tadr_q     <= d_next;
            last_q     <= d_last;
            irq_stop_q <= mem_data_i[TAG_IRQ_BIT] && tie_q;
            if (d_stall)          state_q <= ST_STALL;
            else if (t_qwc != '0) state_q <= ST_DATA;
            else                  state_q <= ST_FIN;
          end
        end
        ST_STALL: if (!stall_i) state_q <= (qcnt_q != '0) ? ST_DATA : ST_FIN;
        ST_DATA: if (take) begin
          madr_q <= madr_q + ADDR_W'(1);
          qcnt_q <= qcnt_q - QCNT_W'(1);
          if (qcnt_q == QCNT_W'(1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          if (last_q || irq_stop_q) begin
            state_q <= ST_IDLE;
            irq_o   <= irq_stop_q;
          end else state_q <= ST_TAG;
        end
        default: ;
      endcase
    end
  end

  assign mem_req_o   = state_q == ST_TAG || state_q == ST_DATA;
  assign mem_addr_o  = (state_q == ST_TAG) ? tadr_q : madr_q;
  assign out_valid_o = take && (state_q == ST_DATA || tte_q);
  assign out_data_o  = mem_data_i;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_CTRL: reg_rdata_o = {tag_hi_q, 7'd0, busy, tie_q, tte_q, 2'(sp), mode_q, 1'b0, dir_q};
      SEL_MADR: reg_rdata_o = 32'(madr_q);
      SEL_QCNT: reg_rdata_o = 32'(qcnt_q);
      SEL_TADR: reg_rdata_o = 32'(tadr_q);
      default:
        for (int i = 0; i < DEPTH; i++)
          if (reg_sel_i == 3'(SEL_STK0 + i)) reg_rdata_o = 32'(stk_ent[i]);
    endcase
  end

  a_r14_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r11_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r13_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && mem_valid_i) |=> qcnt_q == $past(qcnt_q) - QCNT_W'(1));
  a_r7_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL && stall_i) |=> (!out_valid_o && $stable(qcnt_q)));
endmodule

// File: tb/chain_walker_tb_top.sv
`timescale 1ns/1ps
module chain_walker_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         reg_we = 1'b0, stall = 1'b0;
  logic [2:0]   reg_sel = '0;
  logic [31:0]  reg_wdata = '0, reg_rdata;
  logic         mem_req, mem_valid = 1'b0, out_valid, irq;
  logic [30:0]  mem_addr, held_addr = '0;
  logic [127:0] mem_rdata = '0, out_data;
  logic [127:0] mem [64];

  int checks = 0, errors = 0;
  int n_out = 0, sum_out = 0, n_irq = 0, proto_err = 0;

  always #2 clk = ~clk;

  chain_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_data_i(mem_rdata),
    .stall_i(stall), .out_valid_o(out_valid), .out_data_o(out_data), .irq_o(irq)
  );

  // memory responder: one quadword one cycle after a request
  always @(posedge clk) begin
    if (!rst_n) mem_valid <= 1'b0;
    else begin
      if (mem_valid && (!mem_req || mem_addr != held_addr)) proto_err++;
      if (mem_req && !mem_valid) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem[mem_addr[5:0]];
        held_addr <= mem_addr;
      end else mem_valid <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (out_valid) begin n_out++; sum_out += int'(out_data[127:96]); end
    if (irq) n_irq++;
  end

  function automatic logic [63:0] mk_tag(int id, int qwc, int addr, bit fl);
    return {1'b0, 31'(addr), fl, 3'(id), 2'b0, 10'b0, 16'(qwc)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int k = 0; k < 5000; k++) begin
      rd(3'd0, c);
      if (!c[8]) break;
    end
  endtask

  typedef struct packed {
    logic [31:0] ctrl;
    logic [7:0]  tadr, madr, qcnt, n;
    logic [15:0] sum;
    logic [7:0]  etadr;
    logic        eirq;
    logic [15:0] hi;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h104,  8'd0,  8'd0, 8'd0, 8'd7, 16'd179,  8'd13, 1'b0, 16'h0000},
    '{32'h104,  8'd20, 8'd0, 8'd0, 8'd3, 16'd78,   8'd24, 1'b0, 16'h6000},
    '{32'h184,  8'd50, 8'd0, 8'd0, 8'd1, 16'd51,   8'd52, 1'b1, 16'h9000},
    '{32'h104,  8'd50, 8'd0, 8'd0, 8'd2, 16'd104,  8'd5,  1'b0, 16'h7000},
    '{32'h144,  8'd50, 8'd0, 8'd0, 8'd4, 16'd206,  8'd5,  1'b0, 16'h7000},
    '{32'h124,  8'd55, 8'd0, 8'd0, 8'd0, 16'd0,    8'd55, 1'b0, 16'h5000},
    '{32'h100,  8'd7,  8'd40, 8'd3, 8'd3, 16'd123, 8'd7,  1'b0, 16'h5000},
    '{32'h184,  8'd0,  8'd0, 8'd0, 8'd7, 16'd179,  8'd13, 1'b0, 16'h0000}
  };

  function automatic string row_req(int i);
    case (i)
      0: return "R4 R5 R6 R7";
      1: return "R8 R9 R10";
      2: return "R11";
      3: return "R5 R3";
      4: return "R12";
      5: return "R8";
      6: return "R13";
      default: return "R11 R6";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int b_n, b_s, b_i;
    for (int a = 0; a < 64; a++) mem[a] = {32'(a), 32'hC0DE0000, 64'h0};
    mem[0][63:0]  = mk_tag(1, 2, 0, 0);
    mem[3][63:0]  = mk_tag(2, 1, 10, 0);
    mem[10][63:0] = mk_tag(3, 2, 40, 0);
    mem[11][63:0] = mk_tag(4, 1, 45, 0);
    mem[12][63:0] = mk_tag(0, 1, 46, 0);
    mem[20][63:0] = mk_tag(5, 1, 30, 0);
    mem[30][63:0] = mk_tag(5, 0, 33, 0);
    mem[33][63:0] = mk_tag(6, 1, 0, 0);
    mem[31][63:0] = mk_tag(6, 0, 0, 0);
    mem[22][63:0] = mk_tag(6, 1, 0, 0);
    mem[50][63:0] = mk_tag(1, 1, 0, 1);
    mem[52][63:0] = mk_tag(7, 1, 5, 0);
    mem[55][63:0] = mk_tag(5, 1, 0, 0);

    repeat (3) @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 req", 32'(mem_req), 0);
    check("R1 out", 32'(out_valid), 0);
    check("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: idle register access
    wr(3'd1, 32'h1234); rd(3'd1, v); check("R2 madr", v, 32'h1234);
    wr(3'd2, 32'hBEEF); rd(3'd2, v); check("R2 qcnt", v, 32'hBEEF);

    for (int i = 0; i < 8; i++) begin
      wr(3'd3, 32'(VECS[i].tadr));
      wr(3'd1, 32'(VECS[i].madr));
      wr(3'd2, 32'(VECS[i].qcnt));
      b_n = n_out; b_s = sum_out; b_i = n_irq;
      wr(3'd0, VECS[i].ctrl);
      wait_idle();
      repeat (3) @(negedge clk);
      check({row_req(i), " count"}, 32'(n_out - b_n), 32'(VECS[i].n));
      check({row_req(i), " sum"}, 32'(sum_out - b_s), 32'(VECS[i].sum));
      check({row_req(i), " irq"}, 32'(n_irq - b_i), 32'(VECS[i].eirq));
      rd(3'd3, v); check({row_req(i), " tadr"}, v, 32'(VECS[i].etadr));
      rd(3'd0, v);
      check({row_req(i), " R3 hi"}, {16'h0, v[31:16]}, 32'(VECS[i].hi));
      check({row_req(i), " done"}, 32'(v[8]), 0);
      if (i == 1) begin
        check("R9 sp", 32'(v[5:4]), 0);
        rd(3'd4, v); check("R8 stack0", v, 32'd22);
        rd(3'd5, v); check("R8 stack1", v, 32'd31);
      end
      if (i == 5) check("R8 full sp", 32'(v[5:4]), 2);
    end

    // R7 stall hold, R2 writes while busy ignored
    stall = 1'b1;
    wr(3'd3, 32'd0);
    b_n = n_out; b_s = sum_out;
    wr(3'd0, 32'h104);
    repeat (200) @(negedge clk);
    check("R7 stalled count", 32'(n_out - b_n), 5);
    rd(3'd0, v); check("R7 busy", 32'(v[8]), 1);
    wr(3'd3, 32'd63);
    wr(3'd0, 32'h0);
    stall = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    check("R7 total count", 32'(n_out - b_n), 7);
    check("R7 total sum", 32'(sum_out - b_s), 179);
    rd(3'd3, v); check("R2 busy tadr write", v, 32'd13);
    rd(3'd0, v); check("R2 busy ctrl write", 32'(v[3:2]), 1);
    check("R14 protocol", 32'(proto_err), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule